// File: doc/BRIEF.md
# Register Bank with Same-Cycle Write Forwarding

This block holds the general-purpose registers of a pipelined processor core. The decode stage looks up two source registers through two independent combinational read ports. The write-back stage drives the single write port with the destination index, result and enable carried in its own pipeline fields. It does not take them from the instruction currently in decode.

A write and a read of the same register in one cycle behave as if the write happened in the first half of the cycle and the read in the second. When an enabled write targets the register a port is reading, that port returns the incoming write data directly. The stored copy is updated on the next rising clock edge. Register 0 is hard-wired to zero: it ignores writes, and a write aimed at it is never forwarded.

Top module: `regbank_wbr`

## Requirements
- R1: After a synchronous active-low reset, every register reads back as zero on both read ports.
- R2: When `wr_en` is 1 and `wr_addr` is not 0, `wr_data` is stored at the rising clock edge, and later reads of that index return it until it is written again.
- R3: When `wr_en` is 0, no register changes, whatever `wr_addr` and `wr_data` carry.
- R4: Index 0 always reads as zero, and an enabled write to index 0 leaves it zero.
- R5: In a cycle where `wr_en` is 1, `wr_addr` is not 0 and equals a port's read index, that port outputs `wr_data` in the same cycle, before the edge that stores it.
- R6: Forwarding never applies to index 0: reading index 0 while an enabled write targets index 0 returns zero.
- R7: The two read ports are independent. Both may carry the same index, and each then returns the same value.
- R8: A port whose read index differs from the write index returns the stored value, unaffected by the write in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; stores on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset; clears all registers |
| rd_addr_a | input | ADDR_W (5) | Read index, port A |
| rd_data_a | output | DATA_W (32) | Read data, port A (combinational) |
| rd_addr_b | input | ADDR_W (5) | Read index, port B |
| rd_data_b | output | DATA_W (32) | Read data, port B (combinational) |
| wr_en | input | 1 | Write enable from write-back |
| wr_addr | input | ADDR_W (5) | Destination index from write-back |
| wr_data | input | DATA_W (32) | Result from write-back |

## Verification
The assertions assume that every index input is known and within range. Stimulus meets this because indices are only drawn from the full range of ADDR_W bits, which covers exactly NUM_REGS entries.

The assertions also assume that write and read inputs are held steady around each clock edge. The bench drives every input on the falling edge and samples the outputs before the next rising edge.

Random cycles mix enabled and disabled writes. Narrow index draws make forwarding hits, same-index port pairs and writes to index 0 frequent, and directed cycles cover each of these corners explicitly.

// File: rtl/regbank_pkg.sv
// Package: shared defaults and the source selector of a read port.
// Assumes: consumers size their own vectors from module parameters.
package regbank_pkg;

    localparam int REGS_DEFAULT  = 32;
    localparam int WIDTH_DEFAULT = 32;

    // Where a read port takes its value from in a given cycle.
    typedef enum logic [1:0] {
        SRC_ZERO  = 2'd0,
        SRC_ARRAY = 2'd1,
        SRC_WRITE = 2'd2
    } rd_src_e;

endpackage

// File: rtl/regbank_store.sv
// Module: regbank_store
// Holds the register array and applies the write-back write at the rising edge.
// Assumes: waddr < NUM_REGS; entry 0 is never written and stays zero.
module regbank_store #(
    parameter int NUM_REGS = regbank_pkg::REGS_DEFAULT,
    parameter int DATA_W   = regbank_pkg::WIDTH_DEFAULT,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wen,
    input  logic [ADDR_W-1:0]                waddr,
    input  logic [DATA_W-1:0]                wdata,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  table_q
);

    logic write_ok;

    // Purpose: qualify the write; index 0 is read-only.
    always_comb begin
        write_ok = wen && (waddr != '0);
    end

    // Purpose: clear on reset, otherwise store the qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            table_q <= '0;
        end else if (write_ok) begin
            table_q[waddr] <= wdata;
        end
    end

    // R2: an enabled nonzero write is visible in the array after the edge.
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wen && waddr != '0) |=> (table_q[$past(waddr)] == $past(wdata)));

    // R3: with the enable low, the whole array holds.
    p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wen) |=> $stable(table_q));

    // R4: entry 0 stays zero even when a write targets it.
    p_zero_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wen && waddr == '0) |=> (table_q[0] == '0));

endmodule

// File: rtl/regbank_rdport.sv
// Module: regbank_rdport
// One combinational read port: array lookup plus forwarding of a same-cycle write.
// Assumes: raddr and waddr < NUM_REGS; clk and rst_n only clock the assertions.
module regbank_rdport
    import regbank_pkg::*;
#(
    parameter int NUM_REGS = REGS_DEFAULT,
    parameter int DATA_W   = WIDTH_DEFAULT,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [ADDR_W-1:0]                raddr,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  table_q,
    input  logic                             wen,
    input  logic [ADDR_W-1:0]                waddr,
    input  logic [DATA_W-1:0]                wdata,
    output logic [DATA_W-1:0]                rdata
);

    rd_src_e src;

    // Purpose: decide whether zero, the array or the write bus feeds the port.
    always_comb begin
        if (raddr == '0) begin
            src = SRC_ZERO;
        end else if (wen && (waddr == raddr)) begin
            src = SRC_WRITE;
        end else begin
            src = SRC_ARRAY;
        end
    end

    // Purpose: steer the selected source onto the output.
    always_comb begin
        unique case (src)
            SRC_ZERO:  rdata = '0;
            SRC_WRITE: rdata = wdata;
            default:   rdata = table_q[raddr];
        endcase
    end

    // R4 / R6: index 0 reads zero, even when a write targets it.
    p_zero_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (raddr == '0) |-> (rdata == '0));

    // R5: a matching nonzero write is seen in the same cycle.
    p_forward_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wen && raddr != '0 && waddr == raddr) |-> (rdata == wdata));

    // R8: a non-matching read returns the stored value.
    p_no_forward_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (raddr != '0 && !(wen && waddr == raddr)) |-> (rdata == table_q[raddr]));

endmodule

// File: rtl/regbank_wbr.sv
// Module: regbank_wbr
// Register bank with two combinational read ports and one write port.
// A same-cycle write forwards to any port reading the same nonzero index.
// Assumes: write fields come from the write-back stage; indices are in range.
module regbank_wbr
    import regbank_pkg::*;
#(
    parameter int NUM_REGS = REGS_DEFAULT,
    parameter int DATA_W   = WIDTH_DEFAULT,
    localparam int ADDR_W  = $clog2(NUM_REGS),
    localparam int N_RD    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [DATA_W-1:0] rd_data_b,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);

    logic [NUM_REGS-1:0][DATA_W-1:0] table_q;
    logic [N_RD-1:0][ADDR_W-1:0]     rd_addr;
    logic [N_RD-1:0][DATA_W-1:0]     rd_data;

    // Purpose: gather the port indices so the read ports can be generated.
    always_comb begin
        rd_addr[0] = rd_addr_a;
        rd_addr[1] = rd_addr_b;
    end

    assign rd_data_a = rd_data[0];
    assign rd_data_b = rd_data[1];

    regbank_store #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wen     (wr_en),
        .waddr   (wr_addr),
        .wdata   (wr_data),
        .table_q (table_q)
    );

    for (genvar p = 0; p < N_RD; p++) begin : g_port
        regbank_rdport #(
            .NUM_REGS (NUM_REGS),
            .DATA_W   (DATA_W)
        ) u_rd (
            .clk     (clk),
            .rst_n   (rst_n),
            .raddr   (rd_addr[p]),
            .table_q (table_q),
            .wen     (wr_en),
            .waddr   (wr_addr),
            .wdata   (wr_data),
            .rdata   (rd_data[p])
        );
    end

    // R7: equal indices on both ports give equal data.
    p_ports_agree_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_a == rd_addr_b) |-> (rd_data_a == rd_data_b));

endmodule

// File: tb/sim_regbank_wbr.sv
// Bench for regbank_wbr: directed corners plus seeded random cycles against a model.
module sim_regbank_wbr;

    localparam int NR = 32;
    localparam int DW = 32;
    localparam int AW = $clog2(NR);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ra_a = '0, ra_b = '0, wa = '0;
    logic [DW-1:0] wd = '0;
    logic          we = 1'b0;
    logic [DW-1:0] rdat_a, rdat_b;

    logic [DW-1:0] model [NR];
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    regbank_wbr u0 (
        .clk(clk), .rst_n(rst_n),
        .rd_addr_a(ra_a), .rd_data_a(rdat_a),
        .rd_addr_b(ra_b), .rd_data_b(rdat_b),
        .wr_en(we), .wr_addr(wa), .wr_data(wd)
    );

    // Expected port value from the requirements (R4, R5, R6, R8).
    function automatic logic [DW-1:0] expect_rd(input logic [AW-1:0] ra);
        if (ra == '0) return '0;
        if (we && wa == ra) return wd;
        return model[ra];
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive on the falling edge, check before the rising edge, update the model.
    task automatic step(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [AW-1:0] r0, input logic [AW-1:0] r1, input string req);
        @(negedge clk);
        we = w; wa = a; wd = d; ra_a = r0; ra_b = r1;
        #1;
        check(req, rdat_a, expect_rd(r0));
        check(req, rdat_b, expect_rd(r1));
        @(posedge clk);
        if (rst_n && w && a != '0) model[a] = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'h5eed_0a17);
        for (int i = 0; i < NR; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: every index reads zero after reset.
        for (int i = 0; i < NR; i += 2) step(1'b0, '0, '0, AW'(i), AW'(i + 1), "R1");

        // R2: store then read back next cycle.
        step(1'b1, 5'd5, 32'hCAFE_0005, 5'd1, 5'd2, "R2");
        step(1'b0, '0, '0, 5'd5, 5'd3, "R2");

        // R3: disabled write leaves r6 unchanged.
        step(1'b1, 5'd6, 32'h1111_6666, 5'd0, 5'd0, "R3");
        step(1'b0, 5'd6, 32'hDEAD_BEEF, 5'd0, 5'd0, "R3");
        step(1'b0, '0, '0, 5'd6, 5'd6, "R3");

        // R4: write to index 0 is ignored.
        step(1'b1, 5'd0, 32'hFFFF_FFFF, 5'd1, 5'd2, "R4");
        step(1'b0, '0, '0, 5'd0, 5'd0, "R4");

        // R5: forwarding on both ports, then the stored value.
        step(1'b1, 5'd7, 32'hABCD_0007, 5'd7, 5'd7, "R5");
        step(1'b0, '0, '0, 5'd7, 5'd1, "R5");
        step(1'b1, 5'd31, 32'h0F0F_1F1F, 5'd4, 5'd31, "R5");

        // R6: no forwarding for index 0.
        step(1'b1, 5'd0, 32'h7777_7777, 5'd0, 5'd0, "R6");

        // R7: same index on both ports.
        step(1'b0, '0, '0, 5'd5, 5'd5, "R7");

        // R8: write elsewhere does not disturb a read.
        step(1'b1, 5'd9, 32'h9999_0009, 5'd10, 5'd5, "R8");
        step(1'b1, 5'd10, 32'h1010_1010, 5'd9, 5'd7, "R8");

        // Random mix; narrow index draws make hits frequent.
        for (int n = 0; n < 3000; n++) begin
            logic [AW-1:0] a, r0, r1;
            logic w;
            w  = ($urandom % 4) != 0;
            a  = AW'($urandom % 8);
            r0 = AW'($urandom % 8);
            r1 = (($urandom % 4) == 0) ? r0 : AW'($urandom % 8);
            step(w, a, $urandom, r0, r1, (w && (a == r0 || a == r1)) ? "R5" : "R2");
        end

        // R1: reset clears everything again.
        @(negedge clk) rst_n = 1'b0; we = 1'b0;
        @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        for (int i = 0; i < NR; i++) model[i] = '0;
        for (int i = 0; i < NR; i += 2) step(1'b0, '0, '0, AW'(i), AW'(i + 1), "R1");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule